// File: doc/BRIEF.md
# Go-Back-N Sender Window Controller

This block sits on the transmit side of a reliable link and decides, cycle by cycle, which frame sequence number goes out next. When the upstream source offers a new frame and fewer than `WIN` frames are awaiting acknowledgement, the controller issues a send request that carries the next 3-bit sequence number. It then waits for the receiver's verdict. A receive-ready acknowledgement slides the window forward. A reject, or silence that lasts longer than a timeout, makes the controller go back to the oldest unconfirmed frame and send everything from there again, in the original order.

A send request is a single-cycle indication. When `send_valid` is high and `send_retx` is low, the offered frame is taken in that cycle. When both are high, the buffer outside the block must replay the stored frame whose number is `send_seq`. Acknowledgements arrive as a one-cycle strobe with a type bit and a sequence number. Frame storage, checksum generation and the receiving side live elsewhere.

Top module: `gbn_sender`

## Requirements
- R1: After reset no frame is outstanding, `send_valid` stays low while `frame_ready` is low, and the first frame offered is sent with sequence number 0 and `send_retx` low.
- R2: New frames take consecutive sequence numbers modulo 8 (7 is followed by 0). Each is issued with `send_retx` low, and the offered frame counts as taken only in a cycle with `send_valid` high and `send_retx` low.
- R3: While the number of sent but unconfirmed frames equals `WIN`, no new frame is issued.
- R4: A receive-ready (`ack_rej` = 0) carrying N confirms every frame before N. The oldest unconfirmed number becomes N, and the freed places in the window become available in the next cycle.
- R5: A receive-ready whose N is the oldest unconfirmed number or lies beyond the last frame sent, and a reject (`ack_rej` = 1) whose N is not an unconfirmed frame, change nothing.
- R6: After an accepted reject for frame N, the next cycle carries a retransmission of N with `send_retx` high. The following cycles resend N+1 and onwards up to the newest frame sent, and new frames then resume.
- R7: While a retransmission is pending it is issued ahead of any newly offered frame.
- R8: If frames are outstanding and the oldest number has not moved for `TIMEOUT` cycles, the controller rewinds to the oldest unconfirmed frame. The retransmission of that frame appears in the cycle after the timeout.
- R9: The timeout count restarts whenever the oldest unconfirmed number moves or a rewind occurs, and no timeout occurs while nothing is outstanding.
- R10: A receive-ready that confirms frames still queued for retransmission removes them from the resend sequence, so resending continues at N.
- R11: A new frame issued in the same cycle as an accepted reject counts as sent, and it is included in the resend sequence that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_ready | input | 1 | A new frame is offered by the source |
| ack_valid | input | 1 | Acknowledgement strobe, one cycle per acknowledgement |
| ack_rej | input | 1 | Acknowledgement type: 0 receive-ready, 1 reject |
| ack_seq | input | 3 | Sequence number carried by the acknowledgement |
| send_valid | output | 1 | A frame is sent in this cycle |
| send_retx | output | 1 | The frame sent is a retransmission |
| send_seq | output | 3 | Sequence number of the frame sent |

## Verification
The case that needs care is a send and an accepted acknowledgement in the same cycle, because both change the pointers at one clock edge. The bench sets up three such cycles. In the first, a reject arrives while a new frame goes out. In the second, a receive-ready arrives during a resend and overtakes the frames still queued. In the third, a receive-ready lands while the window is full. The outcome is judged by the sequence numbers and the retransmit flag seen in the following cycles, and by whether the window opens or stays shut.

// File: rtl/gbn_pkg.sv
package gbn_pkg;

    localparam int SEQ_W = 3;

    typedef logic [SEQ_W-1:0] seq_t;

    typedef enum logic {
        ACK_READY  = 1'b0,
        ACK_REJECT = 1'b1
    } ack_kind_e;

    // base: oldest unconfirmed, next: next to issue, top: one past newest sent
    typedef struct packed {
        seq_t base;
        seq_t next;
        seq_t top;
    } win_state_t;

endpackage

// File: rtl/gbn_ack_filter.sv
module gbn_ack_filter
    import gbn_pkg::*;
(
    input  logic ack_valid,
    input  logic ack_rej,
    input  seq_t ack_seq,
    input  seq_t base_q,
    input  seq_t top_q,
    output logic rr_ok,
    output logic rej_ok
);

    seq_t rel_n;
    seq_t outst;

    always_comb begin
        rel_n  = ack_seq - base_q;
        outst  = top_q - base_q;
        rr_ok  = 1'b0;
        rej_ok = 1'b0;
        if (ack_valid) begin
            if (ack_kind_e'(ack_rej) == ACK_READY) begin
                // must confirm at least one frame and no frame beyond the newest
                rr_ok = (rel_n != '0) && (rel_n <= outst);
            end else begin
                // must name a frame that is still unconfirmed
                rej_ok = (rel_n < outst);
            end
        end
    end

endmodule

// File: rtl/gbn_send_sel.sv
module gbn_send_sel
    import gbn_pkg::*;
#(
    parameter int WIN = 7
) (
    input  logic frame_ready,
    input  seq_t base_q,
    input  seq_t next_q,
    input  seq_t top_q,
    output logic send_valid,
    output logic send_retx,
    output logic new_send
);

    localparam seq_t WIN_S = seq_t'(WIN);

    logic retx_pend;
    logic room;

    always_comb begin
        retx_pend  = (next_q != top_q);
        room       = ((top_q - base_q) < WIN_S);
        new_send   = !retx_pend && frame_ready && room;
        send_retx  = retx_pend;
        send_valid = retx_pend || new_send;
    end

endmodule

// File: rtl/gbn_retx_timer.sv
module gbn_retx_timer #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic timeout
);

    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        timeout = run && (cnt_q == LAST);
        if (!run || restart || timeout) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R9: after a timeout the count starts over, so two never come back to back
    p_timeout_spaced_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout)
        else $error("timeout fired on consecutive cycles");

endmodule

// File: rtl/gbn_sender.sv
module gbn_sender
    import gbn_pkg::*;
#(
    parameter int WIN     = 7,
    parameter int TIMEOUT = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_ready,
    input  logic                  ack_valid,
    input  logic                  ack_rej,
    input  logic [SEQ_W-1:0]      ack_seq,
    output logic                  send_valid,
    output logic                  send_retx,
    output logic [SEQ_W-1:0]      send_seq
);

    localparam seq_t WIN_S = seq_t'(WIN);

    win_state_t st_d, st_q;

    logic rr_ok, rej_ok, new_send, tmo, rewind, restart;
    seq_t outst, next_adv, rel_n, rel_next;

    gbn_ack_filter u_ack (
        .ack_valid (ack_valid),
        .ack_rej   (ack_rej),
        .ack_seq   (ack_seq),
        .base_q    (st_q.base),
        .top_q     (st_q.top),
        .rr_ok     (rr_ok),
        .rej_ok    (rej_ok)
    );

    gbn_send_sel #(.WIN(WIN)) u_sel (
        .frame_ready (frame_ready),
        .base_q      (st_q.base),
        .next_q      (st_q.next),
        .top_q       (st_q.top),
        .send_valid  (send_valid),
        .send_retx   (send_retx),
        .new_send    (new_send)
    );

    gbn_retx_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (outst != '0),
        .restart (restart),
        .timeout (tmo)
    );

    assign send_seq = st_q.next;

    always_comb begin
        st_d     = st_q;
        outst    = st_q.top - st_q.base;
        next_adv = st_q.next + seq_t'(send_valid);
        rel_n    = ack_seq - st_q.base;
        rel_next = next_adv - st_q.base;
        rewind   = rej_ok || tmo;

        // a frame offered and taken this cycle always extends the sent range
        st_d.top = st_q.top + seq_t'(new_send);

        if (rr_ok || rej_ok) begin
            st_d.base = ack_seq;
        end

        if (rewind) begin
            st_d.next = st_d.base;
        end else if (rr_ok && (rel_n > rel_next)) begin
            // confirmed frames still waiting for a resend are skipped
            st_d.next = ack_seq;
        end else begin
            st_d.next = next_adv;
        end

        restart = rewind || (st_d.base != st_q.base);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: the sent-but-unconfirmed count never exceeds the window
    p_window_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.top - st_q.base) <= WIN_S)
        else $error("outstanding count above window");

    // R3: a full window admits no new frame
    p_full_blocks_new_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.top - st_q.base) == WIN_S) |-> !(send_valid && !send_retx))
        else $error("new frame issued with full window");

    // R4: an accepted receive-ready moves the oldest number to the one it carries
    p_ready_moves_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rr_ok |=> st_q.base == $past(ack_seq))
        else $error("receive-ready did not move the window");

    // R6: an accepted reject is answered by resending the named frame next cycle
    p_reject_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rej_ok |=> (send_valid && send_retx && send_seq == $past(ack_seq)))
        else $error("reject not followed by resend of the named frame");

    // R8: a timeout with no acknowledgement resends the oldest frame next cycle
    p_timeout_rewinds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && !rr_ok && !rej_ok) |=>
            (send_valid && send_retx && send_seq == $past(st_q.base)))
        else $error("timeout not followed by resend of the oldest frame");

    // R9: with nothing outstanding there is nothing to resend
    p_idle_no_resend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.top == st_q.base) |-> !send_retx)
        else $error("resend with empty window");

endmodule

// File: tb/gbn_sender_test.sv
`timescale 1ns/1ps
module gbn_sender_test;

    localparam int WIN = 4;
    localparam int TMO = 20;
    localparam int NV  = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_ready = 1'b0;
    logic       ack_valid = 1'b0;
    logic       ack_rej = 1'b0;
    logic [2:0] ack_seq = 3'd0;
    logic       send_valid, send_retx;
    logic [2:0] send_seq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    gbn_sender #(.WIN(WIN), .TIMEOUT(TMO)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_ready (frame_ready),
        .ack_valid   (ack_valid),
        .ack_rej     (ack_rej),
        .ack_seq     (ack_seq),
        .send_valid  (send_valid),
        .send_retx   (send_retx),
        .send_seq    (send_seq)
    );

    // {frame_ready, ack_valid, ack_rej, ack_seq, exp_valid, exp_retx, exp_seq, req}
    localparam logic [14:0] VEC [NV] = '{
        {1'b0,1'b0,1'b0,3'd0, 1'b0,1'b0,3'd0, 4'd1},  //  0 R1 idle after reset
        {1'b1,1'b0,1'b0,3'd0, 1'b1,1'b0,3'd0, 4'd1},  //  1 R1 first frame is 0
        {1'b1,1'b0,1'b0,3'd0, 1'b1,1'b0,3'd1, 4'd2},  //  2 R2
        {1'b1,1'b0,1'b0,3'd0, 1'b1,1'b0,3'd2, 4'd2},  //  3 R2
        {1'b1,1'b0,1'b0,3'd0, 1'b1,1'b0,3'd3, 4'd2},  //  4 R2 window now full
        {1'b1,1'b0,1'b0,3'd0, 1'b0,1'b0,3'd0, 4'd3},  //  5 R3 blocked
        {1'b1,1'b1,1'b0,3'd2, 1'b0,1'b0,3'd0, 4'd3},  //  6 R3 ack lands while full
        {1'b1,1'b0,1'b0,3'd0, 1'b1,1'b0,3'd4, 4'd4},  //  7 R4 window reopened
        {1'b0,1'b1,1'b0,3'd7, 1'b0,1'b0,3'd0, 4'd5},  //  8 R5 ready beyond newest
        {1'b0,1'b1,1'b1,3'd1, 1'b0,1'b0,3'd0, 4'd5},  //  9 R5 reject of confirmed
        {1'b0,1'b0,1'b0,3'd0, 1'b0,1'b0,3'd0, 4'd5},  // 10 R5 no resend followed
        {1'b1,1'b0,1'b0,3'd0, 1'b1,1'b0,3'd5, 4'd5},  // 11 R5 one place left
        {1'b1,1'b0,1'b0,3'd0, 1'b0,1'b0,3'd0, 4'd5},  // 12 R5 base unchanged
        {1'b0,1'b1,1'b1,3'd3, 1'b0,1'b0,3'd0, 4'd6},  // 13 R6 reject 3
        {1'b1,1'b0,1'b0,3'd0, 1'b1,1'b1,3'd3, 4'd7},  // 14 R7 resend beats new
        {1'b1,1'b0,1'b0,3'd0, 1'b1,1'b1,3'd4, 4'd6},  // 15 R6
        {1'b1,1'b1,1'b0,3'd5, 1'b1,1'b1,3'd5, 4'd6},  // 16 R6 ready 5 with resend
        {1'b1,1'b0,1'b0,3'd0, 1'b1,1'b0,3'd6, 4'd6},  // 17 R6 new frames resume
        {1'b0,1'b1,1'b1,3'd5, 1'b0,1'b0,3'd0, 4'd6},  // 18 R6 reject 5
        {1'b0,1'b1,1'b0,3'd7, 1'b1,1'b1,3'd5, 4'd10}, // 19 R10 ready 7 mid resend
        {1'b0,1'b0,1'b0,3'd0, 1'b0,1'b0,3'd0, 4'd10}, // 20 R10 frame 6 skipped
        {1'b1,1'b0,1'b0,3'd0, 1'b1,1'b0,3'd7, 4'd2},  // 21 R2
        {1'b1,1'b0,1'b0,3'd0, 1'b1,1'b0,3'd0, 4'd2},  // 22 R2 wrap 7 to 0
        {1'b1,1'b1,1'b1,3'd7, 1'b1,1'b0,3'd1, 4'd11}, // 23 R11 new send with reject
        {1'b1,1'b0,1'b0,3'd0, 1'b1,1'b1,3'd7, 4'd11}, // 24 R11
        {1'b1,1'b0,1'b0,3'd0, 1'b1,1'b1,3'd0, 4'd11}, // 25 R11
        {1'b1,1'b0,1'b0,3'd0, 1'b1,1'b1,3'd1, 4'd11}, // 26 R11 same-cycle frame resent
        {1'b1,1'b0,1'b0,3'd0, 1'b1,1'b0,3'd2, 4'd2},  // 27 R2
        {1'b1,1'b0,1'b0,3'd0, 1'b0,1'b0,3'd0, 4'd3},  // 28 R3 full across wrap
        {1'b0,1'b1,1'b0,3'd3, 1'b0,1'b0,3'd0, 4'd4}   // 29 R4 confirm all
    };

    task automatic check(input bit ok, input int req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic fr, input logic av, input logic rj,
                        input logic [2:0] sq, input logic ev, input logic er,
                        input logic [2:0] es, input int req);
        @(negedge clk);
        frame_ready = fr;
        ack_valid   = av;
        ack_rej     = rj;
        ack_seq     = sq;
        #1;
        check(send_valid == ev, req, "send_valid", int'(send_valid), int'(ev));
        if (ev) begin
            check(send_retx == er, req, "send_retx", int'(send_retx), int'(er));
            check(send_seq == es, req, "send_seq", int'(send_seq), int'(es));
        end
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:9],
                 VEC[i][8], VEC[i][7], VEC[i][6:4], int'(VEC[i][3:0]));
        end

        // R8: one frame (3) sent, then silence until the timeout
        step(1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 3'd3, 8);
        for (int k = 1; k <= TMO; k++) begin
            step(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 8);
        end
        step(1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b1, 3'd3, 8);
        step(1'b0, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0, 3'd0, 8);

        // R9: empty window never times out
        for (int k = 0; k < 3 * TMO; k++) begin
            step(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 9);
        end

        // R9: an advance of the oldest number restarts the count
        step(1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 3'd4, 9);
        step(1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 3'd5, 9);
        for (int k = 0; k < 5; k++) begin
            step(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 9);
        end
        step(1'b0, 1'b1, 1'b0, 3'd5, 1'b0, 1'b0, 3'd0, 9);
        for (int k = 1; k <= TMO; k++) begin
            step(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 9);
        end
        step(1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b1, 3'd5, 9);
        step(1'b0, 1'b1, 1'b0, 3'd6, 1'b0, 1'b0, 3'd0, 9);

        // R1: reset in the middle of traffic
        step(1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 3'd6, 1);
        @(negedge clk);
        rst_n = 1'b0;
        frame_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        frame_ready = 1'b0;
        step(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1);
        step(1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule